// File: doc/BRIEF.md
# Buffered Memory-to-Memory Copy Sequencer

This block steers a copy of a byte range from a source region to a destination region through a small internal staging RAM. Work is cut into chunks. A chunk is as large as the staging buffer, or smaller when fewer bytes are left. For each chunk the sequencer first gathers the bytes with source reads that land in the buffer. It then drains them with destination writes taken out of the buffer. It repeats this until the whole byte count has moved, then raises a one-cycle completion pulse.

A command carries a source base, a destination base, a byte length, a buffer size in units of 32 bytes, and one access size for each side. Requests leave on a read-request port and a write-request port. Each request has an address and a log2 size code, and only one request is open per port at a time. A downstream stage is expected to do arbitration and to split requests into bursts. The staging buffer is reached only with single accesses of at most eight bytes.

Top module: `mcopy_seq`

## Requirements
- R1: A command presented while idle with a length of zero or a buffer size code of zero is rejected. `err` goes high on the next cycle and stays high, `busy` stays low and no request is issued. The next accepted command clears `err`.
- R2: Each chunk holds min(`cmd_bufk`×32, bytes still to move) bytes.
- R3: Within a chunk, every source read completes before the first destination write of that chunk is requested. Chunks run strictly one after another.
- R4: A read request uses size code `cmd_src_size` (0=1, 1=2, 2=4, 3=8 bytes). When fewer bytes than that remain to be read in the chunk, it uses the code of the largest power of two not above that count.
- R5: A write request picks its size code by the same rule from `cmd_dst_size` and the bytes left to drain in the chunk, independently of the read side.
- R6: Read addresses start at `cmd_src` and write addresses at `cmd_dst`. Each advances by the byte count of the previous request on its own side.
- R7: Write data carries the source bytes in order, with byte lane i in bits 8i+7:8i. Read-response lanes at or above the request's byte count are ignored, and write-data lanes above the byte count are zero.
- R8: At most one request is open per port. A request held without `*_ready` keeps its valid, address and size unchanged. The next request on a port waits for the read response or the write completion.
- R9: `done` pulses for exactly one cycle, on the cycle after the final write completion is accepted, and `busy` is low from that cycle on.
- R10: A command presented while `busy` is high is ignored.
- R11: The buffer fill and drain pointers wrap at the programmed buffer size and never index beyond it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_src | input | AW | Source base address |
| cmd_dst | input | AW | Destination base address |
| cmd_len | input | LW | Bytes to copy |
| cmd_bufk | input | KW | Buffer size in units of 32 bytes |
| cmd_src_size | input | 2 | Source access size code |
| cmd_dst_size | input | 2 | Destination access size code |
| busy | output | 1 | A copy is in progress |
| err | output | 1 | Last command was rejected |
| done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address |
| rd_req_size | output | 2 | Read size code |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 64 | Read data lanes |
| wr_req_valid | output | 1 | Write request pending |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | AW | Write address |
| wr_req_size | output | 2 | Write size code |
| wr_req_data | output | 64 | Write data lanes |
| wr_done | input | 1 | Write completed |

## Verification
The assertions in the controller guard several properties on every cycle:
- no write request appears while chunk bytes are still unread;
- each request fits the bytes left in its phase;
- a chunk never exceeds the buffer or the remainder;
- both buffer pointers stay below the programmed size;
- stalled requests hold steady;
- `done` and `err` are only seen with `busy` low.

Some behaviour can only be shown by the bench's scenarios, where a reference model checks every request in turn. That covers the exact order of reads and writes across chunks, the size codes chosen at chunk tails, the contiguous addresses, the data bytes returned through the buffer, the rejection of bad commands, the ignoring of commands that arrive mid-copy, and the cycle of the `done` pulse.

// File: rtl/mcs_pkg.sv
// Package: shared types for the buffered copy sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package mcs_pkg;
    // Controller phases: idle, issue read, await read data, issue write, await write completion
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RDREQ  = 3'd1,
        S_RDWAIT = 3'd2,
        S_WRREQ  = 3'd3,
        S_WRWAIT = 3'd4
    } mcs_state_e;

    localparam int unsigned LANES = 8;   // byte lanes of the data path
endpackage

// File: rtl/mcs_size_pick.sv
// Module: mcs_size_pick
// Picks the access size code for the next request on one side: the
// programmed code, reduced to the largest power of two that fits the
// bytes still left in the current phase of the chunk.
// Assumes: left is non-zero whenever the result is used.
module mcs_size_pick #(
    parameter int unsigned LW = 16
) (
    input  logic [1:0]    prog,
    input  logic [LW-1:0] left,
    output logic [1:0]    eff,
    output logic [LW-1:0] nbytes
);
    logic [1:0] fit;

    // Largest size code whose byte count does not exceed the bytes left
    always_comb begin
        if (left >= LW'(8))      fit = 2'd3;
        else if (left >= LW'(4)) fit = 2'd2;
        else if (left >= LW'(2)) fit = 2'd1;
        else                     fit = 2'd0;
    end

    // Clamp the programmed code and expand to a byte count
    always_comb begin
        eff    = (prog < fit) ? prog : fit;
        nbytes = LW'(1) << eff;
    end
endmodule

// File: rtl/mcs_stage_ram.sv
// Module: mcs_stage_ram
// Byte-wide staging buffer with one write port and one read port of up
// to eight lanes each. Lane addresses wrap at the programmed buffer size.
// Assumes: bufb is a non-zero multiple of 32 not above DEPTH. Contents
// are not reset (plain RAM); only written bytes are ever read.
module mcs_stage_ram #(
    parameter int unsigned DEPTH = 224,
    parameter int unsigned PW    = 8,
    parameter int unsigned LW    = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wptr,
    input  logic [1:0]    wsize,
    input  logic [63:0]   wdata,
    input  logic [PW-1:0] rptr,
    input  logic [1:0]    rsize,
    input  logic [LW-1:0] bufb,
    output logic [63:0]   rdata
);
    import mcs_pkg::*;

    logic [7:0] mem [DEPTH];

    function automatic logic [PW-1:0] wrap_idx(logic [PW-1:0] p, int unsigned lane,
                                               logic [LW-1:0] b);
        logic [LW-1:0] s;
        s = LW'(p) + LW'(lane);
        if (s >= b) s = s - b;
        return PW'(s);
    endfunction

    // Store the valid lanes of a read response
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < int'(LANES); i++) begin
                if (i < (1 << wsize)) mem[wrap_idx(wptr, i, bufb)] <= wdata[8*i +: 8];
            end
        end
    end

    // Present the lanes of the next write, zero above its byte count
    always_comb begin
        rdata = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (i < (1 << rsize)) rdata[8*i +: 8] = mem[wrap_idx(rptr, i, bufb)];
        end
    end
endmodule

// File: rtl/mcs_ctrl.sv
// Module: mcs_ctrl
// Chunk controller: accepts a command, runs fill-then-drain chunks with
// one open request per port, keeps addresses, counters and buffer
// pointers, and signals completion or rejection.
// Assumes: LW is wide enough to hold DEPTH; request sizes arrive from
// the size pickers as byte counts matching the phase counters.
module mcs_ctrl #(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 16,
    parameter int unsigned KW = 3,
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_dst,
    input  logic [LW-1:0] cmd_len,
    input  logic [KW-1:0] cmd_bufk,
    input  logic [1:0]    cmd_src_size,
    input  logic [1:0]    cmd_dst_size,
    input  logic [LW-1:0] rd_n,
    input  logic [LW-1:0] wr_n,
    input  logic          rd_req_ready,
    input  logic          rd_rsp_valid,
    input  logic          wr_req_ready,
    input  logic          wr_done,
    output logic          busy,
    output logic          err,
    output logic          done,
    output logic          rd_req_valid,
    output logic [AW-1:0] rd_req_addr,
    output logic          wr_req_valid,
    output logic [AW-1:0] wr_req_addr,
    output logic [LW-1:0] fill_left,
    output logic [LW-1:0] drain_left,
    output logic [1:0]    src_size,
    output logic [1:0]    dst_size,
    output logic          ram_we,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [LW-1:0] bufb
);
    import mcs_pkg::*;

    mcs_state_e    state;
    logic [AW-1:0] src_cur, dst_cur;
    logic [LW-1:0] remain, chunk;
    logic [LW-1:0] cmd_buf_b, first_chunk, next_chunk, rest;
    logic [LW-1:0] wsum, rsum, wnext, rnext;
    logic          err_q, done_q;
    logic          cmd_bad;

    // Decode the incoming command: buffer bytes, first chunk, validity
    always_comb begin
        cmd_buf_b   = LW'({cmd_bufk, 5'd0});
        first_chunk = (cmd_len < cmd_buf_b) ? cmd_len : cmd_buf_b;
        cmd_bad     = (cmd_len == '0) || (cmd_bufk == '0);
    end

    // Size of the chunk that follows the one now draining
    always_comb begin
        rest       = remain - wr_n;
        next_chunk = (rest < bufb) ? rest : bufb;
    end

    // Advance both buffer pointers with wrap at the buffer size
    always_comb begin
        wsum  = LW'(wptr) + rd_n;
        rsum  = LW'(rptr) + wr_n;
        wnext = (wsum >= bufb) ? wsum - bufb : wsum;
        rnext = (rsum >= bufb) ? rsum - bufb : rsum;
    end

    // Phase sequencing, counters, addresses and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            src_cur    <= '0;
            dst_cur    <= '0;
            remain     <= '0;
            chunk      <= '0;
            fill_left  <= '0;
            drain_left <= '0;
            bufb       <= '0;
            src_size   <= '0;
            dst_size   <= '0;
            wptr       <= '0;
            rptr       <= '0;
            err_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q      <= 1'b0;
                            src_cur    <= cmd_src;
                            dst_cur    <= cmd_dst;
                            remain     <= cmd_len;
                            bufb       <= cmd_buf_b;
                            src_size   <= cmd_src_size;
                            dst_size   <= cmd_dst_size;
                            chunk      <= first_chunk;
                            fill_left  <= first_chunk;
                            drain_left <= '0;
                            wptr       <= '0;
                            rptr       <= '0;
                            state      <= S_RDREQ;
                        end
                    end
                end
                S_RDREQ: begin
                    if (rd_req_ready) state <= S_RDWAIT;
                end
                S_RDWAIT: begin
                    if (rd_rsp_valid) begin
                        src_cur   <= src_cur + AW'(rd_n);
                        fill_left <= fill_left - rd_n;
                        wptr      <= PW'(wnext);
                        if (fill_left == rd_n) begin
                            drain_left <= chunk;
                            state      <= S_WRREQ;
                        end else begin
                            state <= S_RDREQ;
                        end
                    end
                end
                S_WRREQ: begin
                    if (wr_req_ready) state <= S_WRWAIT;
                end
                S_WRWAIT: begin
                    if (wr_done) begin
                        dst_cur    <= dst_cur + AW'(wr_n);
                        drain_left <= drain_left - wr_n;
                        remain     <= rest;
                        rptr       <= PW'(rnext);
                        if (drain_left != wr_n) begin
                            state <= S_WRREQ;
                        end else if (remain == wr_n) begin
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end else begin
                            chunk     <= next_chunk;
                            fill_left <= next_chunk;
                            state     <= S_RDREQ;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the outward view of the state
    always_comb begin
        busy         = (state != S_IDLE);
        err          = err_q;
        done         = done_q;
        rd_req_valid = (state == S_RDREQ);
        wr_req_valid = (state == S_WRREQ);
        rd_req_addr  = src_cur;
        wr_req_addr  = dst_cur;
        ram_we       = (state == S_RDWAIT) && rd_rsp_valid;
    end

    // R3
    drain_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> fill_left == '0);
    // R4
    rd_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_n != '0) && (rd_n <= fill_left));
    // R5
    wr_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> (wr_n != '0) && (wr_n <= drain_left));
    // R2
    chunk_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDREQ) |-> (chunk <= bufb) && (chunk <= remain) && (chunk != '0));
    // R11
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (LW'(wptr) < bufb) && (LW'(rptr) < bufb));
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_n));
    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid && !wr_req_ready |=> wr_req_valid && $stable(wr_req_addr) && $stable(wr_n));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !$past(done));
    // R1
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

// File: rtl/mcopy_seq.sv
// Module: mcopy_seq (top)
// Buffered memory-to-memory copy sequencer: controller, two size pickers
// (source and destination) and the staging RAM.
// Assumes: downstream stages handle arbitration and burst splitting;
// LW is wide enough for the largest buffer in bytes.
module mcopy_seq #(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 16,
    parameter int unsigned KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_dst,
    input  logic [LW-1:0] cmd_len,
    input  logic [KW-1:0] cmd_bufk,
    input  logic [1:0]    cmd_src_size,
    input  logic [1:0]    cmd_dst_size,
    output logic          busy,
    output logic          err,
    output logic          done,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [AW-1:0] rd_req_addr,
    output logic [1:0]    rd_req_size,
    input  logic          rd_rsp_valid,
    input  logic [63:0]   rd_rsp_data,
    output logic          wr_req_valid,
    input  logic          wr_req_ready,
    output logic [AW-1:0] wr_req_addr,
    output logic [1:0]    wr_req_size,
    output logic [63:0]   wr_req_data,
    input  logic          wr_done
);
    localparam int unsigned MAXK  = (1 << KW) - 1;
    localparam int unsigned DEPTH = MAXK * 32;
    localparam int unsigned PW    = $clog2(DEPTH);

    logic [LW-1:0] rd_n, wr_n, fill_left, drain_left, bufb;
    logic [1:0]    src_size, dst_size, rd_eff, wr_eff;
    logic          ram_we;
    logic [PW-1:0] wptr, rptr;

    mcs_ctrl #(.AW(AW), .LW(LW), .KW(KW), .PW(PW)) ctrl_i (
        .clk, .rst_n, .cmd_valid, .cmd_src, .cmd_dst, .cmd_len, .cmd_bufk,
        .cmd_src_size, .cmd_dst_size, .rd_n, .wr_n, .rd_req_ready, .rd_rsp_valid,
        .wr_req_ready, .wr_done, .busy, .err, .done, .rd_req_valid, .rd_req_addr,
        .wr_req_valid, .wr_req_addr, .fill_left, .drain_left, .src_size, .dst_size,
        .ram_we, .wptr, .rptr, .bufb
    );

    mcs_size_pick #(.LW(LW)) src_pick_i (
        .prog(src_size), .left(fill_left), .eff(rd_eff), .nbytes(rd_n)
    );

    mcs_size_pick #(.LW(LW)) dst_pick_i (
        .prog(dst_size), .left(drain_left), .eff(wr_eff), .nbytes(wr_n)
    );

    mcs_stage_ram #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) ram_i (
        .clk, .we(ram_we), .wptr, .wsize(rd_eff), .wdata(rd_rsp_data),
        .rptr, .rsize(wr_eff), .bufb, .rdata(wr_req_data)
    );

    assign rd_req_size = rd_eff;
    assign wr_req_size = wr_eff;
endmodule

// File: tb/mcopy_seq_tb.sv
module mcopy_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_src = '0, cmd_dst = '0;
    logic [15:0] cmd_len = '0;
    logic [2:0]  cmd_bufk = '0;
    logic [1:0]  cmd_src_size = '0, cmd_dst_size = '0;
    logic        busy, err, done;
    logic        rd_req_valid, wr_req_valid;
    logic        rd_req_ready = 1'b0, wr_req_ready = 1'b0;
    logic [31:0] rd_req_addr, wr_req_addr;
    logic [1:0]  rd_req_size, wr_req_size;
    logic        rd_rsp_valid = 1'b0, wr_done = 1'b0;
    logic [63:0] rd_rsp_data = '0, wr_req_data;

    int compared = 0, mismatched = 0;
    bit cmp_on = 0, stall = 0, tog = 0, exp_done = 0;
    bit rd_pend = 0, wr_pend = 0;
    logic [31:0] rd_a;
    logic [1:0]  rd_s;
    bit          q_kind[$];
    logic [31:0] q_addr[$];
    logic [1:0]  q_size[$];
    logic [63:0] q_data[$];

    always #2.5 clk = ~clk;

    mcopy_seq dut_i (.*);

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] src_byte(logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic int pick(int prog, int left);
        int fit;
        fit = (left >= 8) ? 3 : (left >= 4) ? 2 : (left >= 2) ? 1 : 0;
        return (prog < fit) ? prog : fit;
    endfunction

    // Reference model: expected request stream for one command (R2-R7)
    task automatic plan(int src, int dst, int len, int k, int ss, int ds);
        int rem, base, chunk, left, o, s;
        logic [63:0] d;
        rem = len; base = 0;
        while (rem > 0) begin
            chunk = (k * 32 < rem) ? k * 32 : rem;
            left = chunk; o = base;
            while (left > 0) begin
                s = pick(ss, left);
                q_kind.push_back(1'b0); q_addr.push_back(32'(src + o));
                q_size.push_back(2'(s)); q_data.push_back('0);
                o += (1 << s); left -= (1 << s);
            end
            left = chunk; o = base;
            while (left > 0) begin
                s = pick(ds, left);
                d = '0;
                for (int i = 0; i < (1 << s); i++) d[8*i +: 8] = src_byte(32'(src + o + i));
                q_kind.push_back(1'b1); q_addr.push_back(32'(dst + o));
                q_size.push_back(2'(s)); q_data.push_back(d);
                o += (1 << s); left -= (1 << s);
            end
            base += chunk; rem -= chunk;
        end
    endtask

    task automatic pop_cmp(bit kind, logic [31:0] a, logic [1:0] s, logic [63:0] d);
        bit ek;
        logic [31:0] ea;
        logic [1:0] es;
        logic [63:0] ed;
        if (q_kind.size() == 0) begin
            check(0, "R3 R10 unexpected request", {31'd0, kind, a}, 64'd0);
            return;
        end
        ek = q_kind.pop_front(); ea = q_addr.pop_front();
        es = q_size.pop_front(); ed = q_data.pop_front();
        check(ek == kind, "R3 read/write order", 64'(kind), 64'(ek));
        check(ea == a, "R6 request address", 64'(a), 64'(ea));
        check(es == s, kind ? "R5 write size" : "R4 read size", 64'(s), 64'(es));
        if (kind) check(ed == d, "R7 write data", d, ed);
    endtask

    // Responder and per-clock comparison, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            tog = ~tog;
            if (cmp_on) begin
                check(done == exp_done, "R9 done timing", 64'(done), 64'(exp_done));
                check(!(rd_req_valid && wr_req_valid), "R8 one port at a time",
                      64'(rd_req_valid), 64'd0);
            end
            exp_done = 0;
            rd_rsp_valid = 0;
            if (rd_pend) begin
                rd_rsp_valid = 1;
                for (int i = 0; i < 8; i++)
                    rd_rsp_data[8*i +: 8] = (i < (1 << rd_s)) ? src_byte(rd_a + 32'(i)) : 8'hEE;
                rd_pend = 0;
            end
            rd_req_ready = stall ? tog : 1'b1;
            if (rd_req_valid && rd_req_ready) begin
                pop_cmp(1'b0, rd_req_addr, rd_req_size, '0);
                rd_a = rd_req_addr; rd_s = rd_req_size; rd_pend = 1;
            end
            wr_done = 0;
            if (wr_pend) begin
                wr_done = 1; wr_pend = 0;
                if (q_kind.size() == 0) exp_done = 1;
            end
            wr_req_ready = stall ? ~tog : 1'b1;
            if (wr_req_valid && wr_req_ready) begin
                pop_cmp(1'b1, wr_req_addr, wr_req_size, wr_req_data);
                wr_pend = 1;
            end
        end
    end

    task automatic issue(int src, int dst, int len, int k, int ss, int ds);
        @(negedge clk);
        cmd_valid = 1; cmd_src = 32'(src); cmd_dst = 32'(dst); cmd_len = 16'(len);
        cmd_bufk = 3'(k); cmd_src_size = 2'(ss); cmd_dst_size = 2'(ds);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic run(int src, int dst, int len, int k, int ss, int ds, bit intrude);
        int n;
        plan(src, dst, len, k, ss, ds);
        issue(src, dst, len, k, ss, ds);
        check(busy == 1'b1, "R2 copy starts", 64'(busy), 64'd1);
        if (intrude) begin
            repeat (5) @(negedge clk);
            issue(32'h9000, 32'hA000, 40, 1, 3, 3);   // R10 must be ignored
        end
        n = 0;
        while ((busy || q_kind.size() != 0) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(q_kind.size() == 0, "R3 R6 all requests seen", 64'(q_kind.size()), 64'd0);
        check(busy == 1'b0, "R9 back to idle", 64'(busy), 64'd0);
        check(err == 1'b0, "R1 no error on good command", 64'(err), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check({busy, err, done, rd_req_valid, wr_req_valid} == 5'd0, "R9 reset idle",
              64'({busy, err, done, rd_req_valid, wr_req_valid}), 64'd0);
        cmp_on = 1;

        // R1: zero length, then zero buffer size
        issue(32'h100, 32'h200, 0, 2, 2, 2);
        check(err == 1'b1 && busy == 1'b0, "R1 zero length rejected", 64'({err, busy}), 64'b10);
        repeat (4) @(negedge clk);
        check(rd_req_valid == 1'b0, "R1 no request after reject", 64'(rd_req_valid), 64'd0);
        issue(32'h100, 32'h200, 16, 0, 2, 2);
        check(err == 1'b1 && busy == 1'b0, "R1 zero buffer rejected", 64'({err, busy}), 64'b10);

        // R2 R11: several full one-block chunks and a short tail; also clears err (R1)
        run(32'h1000, 32'h2000, 100, 1, 3, 2, 0);
        // R4 R5: tail sizes shrink independently on each side
        run(32'h1103, 32'h2201, 13, 2, 2, 0, 0);
        // R8: stalled handshakes, byte reads into double-word writes
        stall = 1;
        run(32'h3000, 32'h4005, 70, 2, 0, 3, 0);
        stall = 0;
        // R10: command during a copy is ignored; R11 large buffer
        run(32'h5000, 32'h6000, 300, 7, 1, 1, 1);
        // R7: odd length, mixed sizes
        run(32'h7007, 32'h8000, 37, 1, 3, 1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule